// File: doc/BRIEF.md
# Codec Command Port Register File

This block sits on the codec side of a serial audio link and owns the codec's control registers. It watches the bit clock, the frame sync and the outbound serial data. From each frame it extracts the 16-bit tag slot and the two 20-bit command slots that follow it. The remaining audio slots of the frame pass by unused. A command is either a write to one of sixty-four 16-bit registers or a read of one of them. Each read is answered on a parallel read-back port, which a separate status path can use to return the value in the next inbound frame.

The receiver is a small state machine clocked on the falling edge of the bit clock. Its states are S_IDLE, S_TAG, S_ADDR, S_DATA and S_EXEC, and it has these transitions:
- S_IDLE to S_TAG on the first falling edge that sees sync high after it was low.
- S_TAG to S_ADDR after the sixteenth tag bit.
- S_ADDR to S_DATA after the twentieth bit of the command-address slot.
- S_DATA to S_EXEC after the twentieth bit of the command-data slot.
- S_EXEC to S_IDLE unconditionally.

In S_EXEC the decoded command is carried out for one bit clock. Byte indices address the registers, and each register sits on an even index. An odd index therefore lands on the register just below it.

Top module: `cmdport_regfile`

## Requirements
- R1: After reset every register reads as 0000h and rb_valid is low.
- R2: Serial data and sync are sampled on falling bit-clock edges. The first edge where sync is high after a low sample carries tag bit 15. After the 16 tag bits come the 20 bits of the command-address slot and then the 20 bits of the command-data slot, all MSB first. Bits before that edge and after the command-data slot are ignored until sync next rises.
- R3: In the command-address slot, bit 19 selects the operation (1 = read, 0 = write) and bits 18:12 are the 7-bit byte index. Bits 11:0 are ignored.
- R4: In the command-data slot, bits 19:4 are the write data and bits 3:0 are ignored.
- R5: A write takes effect only when tag bit 14 (command-address slot valid) and tag bit 13 (command-data slot valid) are both 1.
- R6: A read with tag bit 14 set pulses rb_valid for exactly one bit-clock period. The pulse starts at the first falling edge after the last command-data bit. During the pulse, rb_index carries the received index and rb_data carries that register's contents.
- R7: Register number = index bits 6:1, so an odd index accesses the register at the even index just below it (01h reads register 00h).
- R8: A qualified write changes exactly one register and leaves all others unchanged.
- R9: A read whose tag bit 14 is 0 produces no rb_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame sync; its rise marks the tag slot |
| ser_din | input | 1 | Outbound serial data, MSB first |
| rb_valid | output | 1 | One-cycle strobe for a completed read |
| rb_index | output | 7 | Byte index received with the read |
| rb_data | output | 16 | Contents of the addressed register |

## Verification
The hardest cases to reach from the ports are the ones where nothing should happen: a write with one slot flag cleared, a read with the command-address flag cleared, and reserved bits that are set. Each of these can only be observed by reading registers back in later frames. The bench therefore fills the reserved fields and the inter-frame gaps with ones. It clears one tag flag at a time. It then issues follow-up reads of the targeted register and of its neighbours. A scoreboard of expected read-backs, taken from a register model in the bench, checks both the values and the number of strobes.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
    localparam int TAG_W  = 16;
    localparam int SLOT_W = 20;
    localparam int CNT_W  = $clog2(SLOT_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_TAG,
        S_ADDR,
        S_DATA,
        S_EXEC
    } rx_state_e;
endpackage

// File: rtl/cmdport_frame_rx.sv
module cmdport_frame_rx
    import cmdport_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              ser_din,
    output logic              cmd_go,
    output logic              cmd_rd,
    output logic              cmd_s1v,
    output logic              cmd_s2v,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DATA_W-1:0] cmd_wdata
);
    localparam int TAG_S1V = TAG_W - 2;
    localparam int TAG_S2V = TAG_W - 3;
    localparam int IDX_LO  = SLOT_W - 1 - IDX_W;
    localparam int DAT_LO  = SLOT_W - DATA_W;

    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [SLOT_W-1:0] sh, sh_nx;
    logic              sync_q, sync_rise;

    assign sh_nx     = {sh[SLOT_W-2:0], ser_din};
    assign sync_rise = frame_sync & ~sync_q;
    assign cmd_go    = (state == S_EXEC);

    // next-state decode
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            S_IDLE: if (sync_rise) begin
                state_nx = S_TAG;
                cnt_nx   = CNT_W'(1);
            end
            S_TAG: if (cnt == CNT_W'(TAG_W - 1)) begin
                state_nx = S_ADDR;
                cnt_nx   = '0;
            end else cnt_nx = cnt + 1'b1;
            S_ADDR: if (cnt == CNT_W'(SLOT_W - 1)) begin
                state_nx = S_DATA;
                cnt_nx   = '0;
            end else cnt_nx = cnt + 1'b1;
            S_DATA: if (cnt == CNT_W'(SLOT_W - 1)) begin
                state_nx = S_EXEC;
                cnt_nx   = '0;
            end else cnt_nx = cnt + 1'b1;
            S_EXEC: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            sync_q <= 1'b0;
            sh     <= '0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            sync_q <= frame_sync;
            sh     <= sh_nx;
        end
    end

    // field capture at slot boundaries
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_rd    <= 1'b0;
            cmd_s1v   <= 1'b0;
            cmd_s2v   <= 1'b0;
            cmd_idx   <= '0;
            cmd_wdata <= '0;
        end else begin
            if (state == S_TAG && cnt == CNT_W'(TAG_W - 1)) begin
                cmd_s1v <= sh_nx[TAG_S1V];
                cmd_s2v <= sh_nx[TAG_S2V];
            end
            if (state == S_ADDR && cnt == CNT_W'(SLOT_W - 1)) begin
                cmd_rd  <= sh_nx[SLOT_W-1];
                cmd_idx <= sh_nx[SLOT_W-2:IDX_LO];
            end
            if (state == S_DATA && cnt == CNT_W'(SLOT_W - 1))
                cmd_wdata <= sh_nx[SLOT_W-1:DAT_LO];
        end
    end

    // R2: stays idle until a sync rise is seen
    p_hold_idle_r2: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (state == S_IDLE && !sync_rise) |=> state == S_IDLE);
    // R2: the command-data slot is followed by the execute cycle
    p_exec_after_data_r2: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (state == S_DATA && cnt == CNT_W'(SLOT_W - 1)) |=> state == S_EXEC);
    // R6: execute lasts a single bit clock
    p_exec_single_r6: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (state == S_EXEC) |=> state == S_IDLE);
endmodule

// File: rtl/cmdport_regbank.sv
module cmdport_regbank #(
    parameter int NREG   = 64,
    parameter int DATA_W = 16,
    localparam int REG_AW = $clog2(NREG),
    localparam int IDX_W  = REG_AW + 1
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_rd,
    input  logic              cmd_s1v,
    input  logic              cmd_s2v,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rb_valid,
    output logic [IDX_W-1:0]  rb_index,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs [NREG];
    logic [NREG-1:0]   we;
    logic [REG_AW-1:0] sel;
    logic              wr_ok, rd_ok;

    assign sel   = cmd_idx[IDX_W-1:1];
    assign wr_ok = cmd_go & cmd_s1v & cmd_s2v & ~cmd_rd;
    assign rd_ok = cmd_go & cmd_s1v & cmd_rd;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign we[i] = wr_ok && (sel == REG_AW'(i));
        always_ff @(negedge bit_clk or negedge rst_n) begin
            if (!rst_n)     regs[i] <= '0;
            else if (we[i]) regs[i] <= cmd_wdata;
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_valid <= 1'b0;
            rb_index <= '0;
            rb_data  <= '0;
        end else begin
            rb_valid <= rd_ok;
            if (rd_ok) begin
                rb_index <= cmd_idx;
                rb_data  <= regs[sel];
            end
        end
    end

    // R8: at most one register enabled per cycle
    p_one_reg_r8: assert property (@(negedge bit_clk) disable iff (!rst_n)
        $onehot0(we));
    // R5: any register enable arrives with both slot flags and a write op
    p_write_qualified_r5: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (|we) |-> (cmd_s1v && cmd_s2v && !cmd_rd && cmd_go));
endmodule

// File: rtl/cmdport_regfile.sv
module cmdport_regfile #(
    parameter int NREG   = 64,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG) + 1
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              ser_din,
    output logic              rb_valid,
    output logic [IDX_W-1:0]  rb_index,
    output logic [DATA_W-1:0] rb_data
);
    logic              cmd_go, cmd_rd, cmd_s1v, cmd_s2v;
    logic [IDX_W-1:0]  cmd_idx;
    logic [DATA_W-1:0] cmd_wdata;

    cmdport_frame_rx #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rx (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .frame_sync(frame_sync),
        .ser_din   (ser_din),
        .cmd_go    (cmd_go),
        .cmd_rd    (cmd_rd),
        .cmd_s1v   (cmd_s1v),
        .cmd_s2v   (cmd_s2v),
        .cmd_idx   (cmd_idx),
        .cmd_wdata (cmd_wdata)
    );

    cmdport_regbank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .cmd_go   (cmd_go),
        .cmd_rd   (cmd_rd),
        .cmd_s1v  (cmd_s1v),
        .cmd_s2v  (cmd_s2v),
        .cmd_idx  (cmd_idx),
        .cmd_wdata(cmd_wdata),
        .rb_valid (rb_valid),
        .rb_index (rb_index),
        .rb_data  (rb_data)
    );

    // R6: strobe is a single-cycle pulse
    p_strobe_pulse_r6: assert property (@(negedge bit_clk) disable iff (!rst_n)
        rb_valid |=> !rb_valid);
    // R9: a strobe only follows a decoded read with the address slot valid
    p_strobe_source_r9: assert property (@(negedge bit_clk) disable iff (!rst_n)
        rb_valid |-> $past(cmd_go && cmd_rd && cmd_s1v));
endmodule

// File: tb/cmdport_regfile_bench.sv
`timescale 1ns/1ps
module cmdport_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        ser_din = 1'b0;
    logic        rb_valid;
    logic [6:0]  rb_index;
    logic [15:0] rb_data;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    int expected_strobes = 0;
    bit done = 1'b0;

    logic [15:0] model [64];
    logic [22:0] exp_q [$];
    string       req_q [$];

    always #2.5 clk = ~clk;

    cmdport_regfile u_cmdport_regfile (
        .bit_clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_din(ser_din),
        .rb_valid(rb_valid), .rb_index(rb_index), .rb_data(rb_data)
    );

    // monitor: pops expected read-backs as strobes appear
    always @(posedge clk) begin
        if (rst_n && rb_valid) begin
            strobes++;
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected strobe: got idx=%h data=%h, expected none", rb_index, rb_data);
            end else begin
                logic [22:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if ({rb_index, rb_data} !== e) begin
                    fails++;
                    $display("FAIL %s read-back: got idx=%h data=%h, expected idx=%h data=%h",
                             r, rb_index, rb_data, e[22:16], e[15:0]);
                end
            end
        end
    end

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h, expected %h", r, act, exp);
        end
    endtask

    task automatic send_bit(input logic s, input logic d);
        @(posedge clk);
        frame_sync <= s;
        ser_din    <= d;
    endtask

    task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2);
        for (int i = 15; i >= 0; i--) send_bit(1'b1, tag[i]);
        for (int i = 19; i >= 0; i--) send_bit(1'b0, s1[i]);
        for (int i = 19; i >= 0; i--) send_bit(1'b0, s2[i]);
    endtask

    task automatic pad(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b1);
    endtask

    task automatic wr(input logic [6:0] idx, input logic [15:0] d, input logic s1v,
                      input logic s2v, input logic [11:0] rsv1, input logic [3:0] rsv2);
        send_frame({1'b1, s1v, s2v, 13'h1FFF}, {1'b0, idx, rsv1}, {d, rsv2});
        if (s1v && s2v) model[idx[6:1]] = d;
        pad(6);
    endtask

    task automatic rd(input logic [6:0] idx, input logic s1v, input string r);
        if (s1v) begin
            exp_q.push_back({idx, model[idx[6:1]]});
            req_q.push_back(r);
            expected_strobes++;
        end
        send_frame({1'b1, s1v, 1'b0, 13'h0}, {1'b1, idx, 12'hFFF}, 20'h0);
        send_bit(1'b0, 1'b1);
        check({r, " strobe low before exec"}, {31'b0, rb_valid}, 32'd0);
        send_bit(1'b0, 1'b1);
        check({r, " strobe at exec"}, {31'b0, rb_valid}, {31'b0, s1v});
        send_bit(1'b0, 1'b1);
        check({r, " strobe one cycle"}, {31'b0, rb_valid}, 32'd0);
        pad(3);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 rb_valid in reset", {31'b0, rb_valid}, 32'd0);
        rst_n <= 1'b1;
        pad(5);                                   // R2 garbage before first sync
        check("R1 rb_valid after reset", {31'b0, rb_valid}, 32'd0);
        rd(7'h00, 1'b1, "R1");
        rd(7'h7E, 1'b1, "R1");
        wr(7'h08, 16'hABCD, 1'b1, 1'b1, 12'h000, 4'h0);
        rd(7'h08, 1'b1, "R5");
        rd(7'h09, 1'b1, "R7");
        wr(7'h0B, 16'h1234, 1'b1, 1'b1, 12'h000, 4'h0);
        rd(7'h0A, 1'b1, "R7");
        rd(7'h08, 1'b1, "R8");
        wr(7'h10, 16'h5A5A, 1'b1, 1'b1, 12'hFFF, 4'hF);
        rd(7'h10, 1'b1, "R3");
        rd(7'h11, 1'b1, "R4");
        wr(7'h10, 16'h0F0F, 1'b1, 1'b0, 12'h000, 4'h0);
        rd(7'h10, 1'b1, "R5");
        wr(7'h10, 16'h0F0F, 1'b0, 1'b1, 12'h000, 4'h0);
        rd(7'h10, 1'b1, "R5");
        rd(7'h10, 1'b0, "R9");
        wr(7'h7E, 16'hFFFF, 1'b1, 1'b1, 12'hABC, 4'h5);
        rd(7'h7F, 1'b1, "R2");
        rd(7'h7C, 1'b1, "R8");
        rd(7'h0E, 1'b1, "R8");
        pad(4);
        check("R6 strobe count", strobes, expected_strobes);
        check("R6 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: got running, expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule